// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte Lanes

This block is a synthesizable model of a small single-port synchronous SRAM with a 64-bit word split into eight byte lanes. An access starts on one of two active-low address strobes. The two lowest address bits are then stepped by an internal two-bit burst counter. A static input selects whether the counter steps in interleaved (XOR) order or in linear (wrapping add) order. A write can be a full-word write, forced by a global write input, or a per-lane write, which uses a group write enable together with eight per-lane enables.

A static mode input selects the read path. With it low the path is flow-through, and read data leaves the RAM output register. With it high the path is pipelined: one more register stage is added, and the per-lane enables and write data are taken one cycle after the address instead of with it. An active-low output enable gates the output without a clock. A sleep input freezes the whole block and keeps the memory contents, and while it is high every other input is ignored. The bidirectional data bus is modelled as separate write and read buses plus a read-valid flag. A low read-valid flag stands for high impedance.

Top module: `sync_burst_sram`

## Requirements
- R1: When `all_wr_n` is 0 in a write access cycle, all eight lanes of the addressed word are written, whatever `lane_n` holds.
- R2: When `all_wr_n` is 1 and `grp_wr_n` is 0, lane i (bits 8i+7..8i) is written only if `lane_n[i]` is 0. The other lanes keep their contents.
- R3: An access with both `all_wr_n` and `grp_wr_n` at 1 is a read. An access started by `strb_cpu_n` low is always a read, whatever the write controls are.
- R4: The word at the start address is accessed first. Each later no-strobe cycle with `step_n` 0 advances a 2-bit count, and a cycle with `step_n` 1 repeats the current word. The low address bits are base XOR count when `order_sel` is 1, and base plus count modulo 4 when it is 0. The upper bits stay fixed.
- R5: With `pipe_mode` 0, read data is valid after the first rising edge that follows the edge sampling the address. With `pipe_mode` 1, it is valid after the second such edge.
- R6: With `pipe_mode` 1, `wr_data` and `lane_n` for a write are sampled on the edge after its address edge. With `pipe_mode` 0, they are sampled together with the address.
- R7: `oe_n` at 1 forces `rd_vld` to 0 at once, without waiting for a clock edge. Returning it to 0 restores the held value.
- R8: While `sleep` is 1, no state changes: the outputs hold, the memory keeps its contents, and strobes, writes and all other inputs are ignored.
- R9: The chip is selected when `sel_n`=0, `sel_hi`=1 and `sel2_n`=0. A strobe in a cycle that is not selected ends any burst, and later no-strobe cycles make no access. The next selected strobe starts a new access at once.
- R10: A write access produces no read slot, so `rd_vld` is 0 in the output cycle that the write occupies.
- R11: During reset, `rd_vld` is 0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Word address, taken when a strobe starts an access |
| strb_cpu_n | input | 1 | Active-low processor strobe; starts a read |
| strb_sys_n | input | 1 | Active-low system strobe; starts a read or a write |
| step_n | input | 1 | Active-low burst advance |
| sel_n | input | 1 | Active-low chip select |
| sel_hi | input | 1 | Active-high chip select |
| sel2_n | input | 1 | Second active-low chip select |
| all_wr_n | input | 1 | Active-low full-word write |
| grp_wr_n | input | 1 | Active-low per-lane write enable |
| lane_n | input | 8 | Active-low per-lane enables |
| wr_data | input | 64 | Write data |
| oe_n | input | 1 | Active-low asynchronous output enable |
| pipe_mode | input | 1 | Static: 1 pipelined, 0 flow-through |
| order_sel | input | 1 | Static: 1 interleaved, 0 linear burst order |
| sleep | input | 1 | Active-high low-power freeze |
| rd_data | output | 64 | Read data (zero when not valid) |
| rd_vld | output | 1 | Read data valid; 0 models high impedance |

## Verification
The hardest situation to reach is a sleep request that arrives while a read result sits in the output stage and a burst is still active. It has to be shown that neither the pending stages nor the held output move, even though the strobes and write controls keep toggling. The stimulus gets there on purpose: it launches a read, parks it in the output register, asserts sleep and drives a full-word write to the same address, and then reads that address back after waking. Random cycles add more cases, with sleep, deselects, strobes, stepping and output-enable pulses mixed under a fixed seed. A cycle model in the bench compares the output every cycle in all four combinations of read mode and burst order.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Low two address bits for burst position cnt from start position base
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input order_e     ord);
    return (ord == ORD_INTERLEAVE) ? (base ^ cnt) : (base + cnt);
  endfunction

endpackage

// File: rtl/sbs_burst_gen.sv
module sbs_burst_gen
  import sbs_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          load,
  input  logic          adv,
  input  order_e        ord,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] acc_addr
);

  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_nx;

  assign cnt_nx = adv ? cnt_q + 2'd1 : cnt_q;

  always_comb begin
    if (load) acc_addr = addr_in;
    else      acc_addr = {base_q[AW-1:2], burst_low(base_q[1:0], cnt_nx, ord)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (!hold) begin
      if (load) begin
        base_q <= addr_in;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_nx;
      end
    end
  end

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!hold && !load && adv) |=> cnt_q == $past(cnt_q) + 2'd1);

  // R4
  base_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (hold || !load) |=> base_q == $past(base_q));

endmodule

// File: rtl/sbs_lane_dec.sv
module sbs_lane_dec #(
  parameter int LANES = 8
) (
  input  logic             all_wr,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] mask
);

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign mask[l] = all_wr | ~lane_n[l];
  end

endmodule

// File: rtl/sbs_store.sv
module sbs_store #(
  parameter int AW    = 8,
  parameter int LW    = 8,
  parameter int LANES = 8
) (
  input  logic                clk,
  input  logic                we,
  input  logic                re,
  input  logic [AW-1:0]       addr,
  input  logic [LANES-1:0]    wmask,
  input  logic [LANES*LW-1:0] wdata,
  output logic [LANES*LW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] bank [DEPTH];
    logic [LW-1:0] q;

    always_ff @(posedge clk) begin
      if (we && wmask[l]) bank[addr] <= wdata[l*LW +: LW];
      if (re)             q          <= bank[addr];
    end

    assign rdata[l*LW +: LW] = q;
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LW    = 8,
  parameter int LANES = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [AW-1:0]       addr,
  input  logic                strb_cpu_n,
  input  logic                strb_sys_n,
  input  logic                step_n,
  input  logic                sel_n,
  input  logic                sel_hi,
  input  logic                sel2_n,
  input  logic                all_wr_n,
  input  logic                grp_wr_n,
  input  logic [LANES-1:0]    lane_n,
  input  logic [LANES*LW-1:0] wr_data,
  input  logic                oe_n,
  input  logic                pipe_mode,
  input  logic                order_sel,
  input  logic                sleep,
  output logic [LANES*LW-1:0] rd_data,
  output logic                rd_vld
);

  localparam int DW = LANES * LW;

  // Access decode
  logic sel, strobe, cpu_go, sys_go, start, cont, wr_dec;
  logic acc_vld, acc_wr, act_d;
  logic [AW-1:0] acc_addr;

  assign sel    = !sel_n && sel_hi && !sel2_n;
  assign strobe = !strb_cpu_n || !strb_sys_n;
  assign cpu_go = !strb_cpu_n && sel;
  assign sys_go = strb_cpu_n && !strb_sys_n && sel;
  assign start  = cpu_go || sys_go;
  assign wr_dec = !all_wr_n || !grp_wr_n;

  // Address stage
  logic             act_q;
  logic             a_vld_q, a_wr_q, a_all_q;
  logic [AW-1:0]    a_addr_q;
  logic [LANES-1:0] a_lane_n_q;
  logic [DW-1:0]    a_data_q;

  assign cont    = !strobe && act_q;
  assign acc_vld = start || cont;
  assign acc_wr  = cpu_go ? 1'b0 : wr_dec;
  assign act_d   = strobe ? start : act_q;

  sbs_burst_gen #(.AW(AW)) i_burst (
    .clk      (clk),
    .rst      (rst),
    .hold     (sleep),
    .load     (start),
    .adv      (cont && !step_n),
    .ord      (order_e'(order_sel)),
    .addr_in  (addr),
    .acc_addr (acc_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      a_vld_q <= 1'b0;
      a_wr_q  <= 1'b0;
    end else if (!sleep) begin
      act_q   <= act_d;
      a_vld_q <= acc_vld;
      a_wr_q  <= acc_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (!sleep) begin
      a_addr_q   <= acc_addr;
      a_all_q    <= !all_wr_n;
      a_lane_n_q <= lane_n;
      a_data_q   <= wr_data;
    end
  end

  // Memory stage: lane enables and data come from the address cycle in
  // flow-through mode and from the current cycle in pipelined mode
  logic             mem_we, mem_re;
  logic [LANES-1:0] lane_src_n, wmask;
  logic [DW-1:0]    wdata_src, ram_q;

  assign lane_src_n = pipe_mode ? lane_n  : a_lane_n_q;
  assign wdata_src  = pipe_mode ? wr_data : a_data_q;
  assign mem_we     = !rst && !sleep && a_vld_q && a_wr_q;
  assign mem_re     = !rst && !sleep && a_vld_q && !a_wr_q;

  sbs_lane_dec #(.LANES(LANES)) i_lanes (
    .all_wr (a_all_q),
    .lane_n (lane_src_n),
    .mask   (wmask)
  );

  sbs_store #(.AW(AW), .LW(LW), .LANES(LANES)) i_store (
    .clk   (clk),
    .we    (mem_we),
    .re    (mem_re),
    .addr  (a_addr_q),
    .wmask (wmask),
    .wdata (wdata_src),
    .rdata (ram_q)
  );

  // Output stages
  logic          rd_vld_q, p_vld_q, out_vld;
  logic [DW-1:0] p_data_q, out_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_q <= 1'b0;
      p_vld_q  <= 1'b0;
    end else if (!sleep) begin
      rd_vld_q <= a_vld_q && !a_wr_q;
      p_vld_q  <= rd_vld_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!sleep) p_data_q <= ram_q;
  end

  assign out_vld  = pipe_mode ? p_vld_q  : rd_vld_q;
  assign out_data = pipe_mode ? p_data_q : ram_q;
  assign rd_vld   = out_vld && !oe_n;
  assign rd_data  = rd_vld ? out_data : '0;

  // R8
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> $stable(rd_vld_q) && $stable(p_vld_q) && $stable(act_q) && $stable(a_vld_q));

  // R10
  write_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (a_vld_q && a_wr_q && !sleep) |=> !rd_vld_q);

  // R5
  read_slot_chk: assert property (@(posedge clk) disable iff (rst)
    (a_vld_q && !a_wr_q && !sleep) |=> rd_vld_q);

  // R9
  desel_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && strobe && !sel) |=> !a_vld_q && !act_q);

  // R3
  cpu_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!sleep && cpu_go) |=> a_vld_q && !a_wr_q);

endmodule

// File: tb/test_sync_burst_sram.sv
module test_sync_burst_sram;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic        strb_cpu_n = 1'b1, strb_sys_n = 1'b1, step_n = 1'b1;
  logic        sel_n = 1'b1, sel_hi = 1'b1, sel2_n = 1'b0;
  logic        all_wr_n = 1'b1, grp_wr_n = 1'b1;
  logic [7:0]  lane_n = 8'hFF;
  logic [63:0] wr_data = '0;
  logic        oe_n = 1'b0, pipe_mode = 1'b0, order_sel = 1'b1, sleep = 1'b0;
  logic [63:0] rd_data;
  logic        rd_vld;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R2";
  bit    cmp_on = 1'b0;

  always #5 clk = ~clk;

  sync_burst_sram i_sync_burst_sram (
    .clk(clk), .rst(rst), .addr(addr), .strb_cpu_n(strb_cpu_n), .strb_sys_n(strb_sys_n),
    .step_n(step_n), .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n), .all_wr_n(all_wr_n),
    .grp_wr_n(grp_wr_n), .lane_n(lane_n), .wr_data(wr_data), .oe_n(oe_n),
    .pipe_mode(pipe_mode), .order_sel(order_sel), .sleep(sleep),
    .rd_data(rd_data), .rd_vld(rd_vld)
  );

  // ---------------- reference functions ----------------
  function automatic logic [63:0] init_word(input logic [7:0] a);
    return {8{a}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  function automatic logic [63:0] merge(input logic [63:0] old_w, input logic [63:0] new_w,
                                        input logic [7:0] en_n);
    logic [63:0] r = old_w;
    for (int l = 0; l < 8; l++) if (!en_n[l]) r[l*8 +: 8] = new_w[l*8 +: 8];
    return r;
  endfunction

  function automatic logic [7:0] burst_addr(input logic [7:0] base, input logic [1:0] k,
                                            input logic ord);
    logic [1:0] lo = ord ? (base[1:0] ^ k) : (base[1:0] + k);
    return {base[7:2], lo};
  endfunction

  // ---------------- cycle model ----------------
  logic [63:0] m_mem [256];
  logic        m_act, m_av, m_aw, m_aall, m_rv, m_pv;
  logic [7:0]  m_base, m_aa, m_aln;
  logic [1:0]  m_cnt;
  logic [63:0] m_ad, m_rd, m_pd;

  always @(posedge clk) begin
    if (rst) begin
      m_act = 0; m_av = 0; m_aw = 0; m_rv = 0; m_pv = 0; m_base = 0; m_cnt = 0;
    end else if (!sleep) begin
      logic        pv_n, sel, strobe, cpu, sys;
      logic [63:0] pd_n, wd;
      logic [7:0]  ln, acc;
      pv_n = m_rv; pd_n = m_rd;
      if (m_av && !m_aw) m_rd = m_mem[m_aa];
      m_rv = m_av && !m_aw;
      if (m_av && m_aw) begin
        wd = pipe_mode ? wr_data : m_ad;
        ln = m_aall ? 8'h00 : (pipe_mode ? lane_n : m_aln);
        m_mem[m_aa] = merge(m_mem[m_aa], wd, ln);
      end
      m_pv = pv_n; m_pd = pd_n;
      sel    = !sel_n && sel_hi && !sel2_n;
      strobe = !strb_cpu_n || !strb_sys_n;
      cpu    = !strb_cpu_n && sel;
      sys    = strb_cpu_n && !strb_sys_n && sel;
      acc    = addr;
      if (cpu || sys) begin
        m_base = addr; m_cnt = 0;
      end else if (m_act) begin
        if (!step_n) m_cnt = m_cnt + 2'd1;
        acc = burst_addr(m_base, m_cnt, order_sel);
      end
      m_av   = cpu || sys || (!strobe && m_act);
      m_aw   = cpu ? 1'b0 : (!all_wr_n || !grp_wr_n);
      m_aa   = acc; m_aall = !all_wr_n; m_aln = lane_n; m_ad = wr_data;
      m_act  = strobe ? (cpu || sys) : m_act;
    end
  end

  task automatic chk(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      logic ev;
      ev = (pipe_mode ? m_pv : m_rv) && !oe_n;
      chk(cur_req, rd_vld == ev, {63'd0, rd_vld}, {63'd0, ev});
      if (ev) chk(cur_req, rd_data == (pipe_mode ? m_pd : m_rd), rd_data, pipe_mode ? m_pd : m_rd);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic step(); @(posedge clk); #2; endtask

  task automatic quiet();
    sel_n = 1; sel_hi = 1; sel2_n = 0; strb_cpu_n = 0; strb_sys_n = 1;
    all_wr_n = 1; grp_wr_n = 1; step_n = 1;
  endtask

  task automatic rd_start(input logic [7:0] a);
    sel_n = 0; sel_hi = 1; sel2_n = 0; strb_cpu_n = 0; strb_sys_n = 1;
    addr = a; all_wr_n = 1; grp_wr_n = 1; step_n = 1;
  endtask

  task automatic wr_start(input logic [7:0] a, input logic aw, input logic gw,
                          input logic [7:0] ln, input logic [63:0] d);
    sel_n = 0; sel_hi = 1; sel2_n = 0; strb_cpu_n = 1; strb_sys_n = 0;
    addr = a; all_wr_n = aw; grp_wr_n = gw; lane_n = ln; wr_data = d; step_n = 1;
  endtask

  task automatic cont(input logic sn, input logic aw, input logic gw,
                      input logic [7:0] ln, input logic [63:0] d);
    strb_cpu_n = 1; strb_sys_n = 1; step_n = sn;
    all_wr_n = aw; grp_wr_n = gw; lane_n = ln; wr_data = d;
  endtask

  task automatic do_reset(input logic pm, input logic ord);
    rst = 1; pipe_mode = pm; order_sel = ord; sleep = 0; oe_n = 0; quiet();
    step(); step();
    chk("R11", rd_vld == 1'b0, {63'd0, rd_vld}, 64'd0);
    rst = 0;
  endtask

  task automatic rand_cycles(input int n);
    for (int i = 0; i < n; i++) begin
      int s = $urandom % 8;
      sleep      = ($urandom % 16) == 0;
      strb_cpu_n = (s != 0);
      strb_sys_n = (s != 1);
      sel_n      = ($urandom % 8) == 0;
      sel_hi     = ($urandom % 16) != 0;
      sel2_n     = 1'b0;
      addr       = 8'($urandom % 64);
      all_wr_n   = ($urandom % 6) != 0;
      grp_wr_n   = ($urandom % 3) != 0;
      lane_n     = 8'($urandom);
      step_n     = 1'($urandom);
      wr_data    = {$urandom, $urandom};
      oe_n       = ($urandom % 10) == 0;
      step();
    end
    sleep = 0; oe_n = 0; quiet(); step(); step(); step();
  endtask

  task automatic burst_check(input logic [7:0] base, input logic ord, input string req);
    rd_start(base); step();
    for (int k = 0; k < 4; k++) begin
      if (k < 3) cont(0, 1, 1, 8'hFF, '0); else quiet();
      step();
      chk(req, rd_vld && rd_data == init_word(burst_addr(base, 2'(k), ord)),
          rd_data, init_word(burst_addr(base, 2'(k), ord)));
    end
    quiet(); step();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [63:0] d1, d2, d6, hold_v;
    void'($urandom(32'd20240611));
    d1 = 64'hDEAD_BEEF_0BAD_F00D;
    d2 = 64'h1122_3344_5566_7788;
    d6 = 64'hCAFE_D00D_FACE_B00C;

    // Phase 1: flow-through, interleaved
    do_reset(0, 1);
    cmp_on = 1; cur_req = "R1";
    for (int b = 0; b < 64; b += 4) begin
      wr_start(8'(b), 0, 1, 8'hFF, init_word(8'(b))); step();
      for (int k = 1; k < 4; k++) begin cont(0, 0, 1, 8'hFF, init_word(8'(b + k))); step(); end
    end
    quiet(); step(); step();

    // R1 full-word write overrides lanes; R10 no read slot for the write
    wr_start(8'h10, 0, 1, 8'hFF, d1); step(); quiet(); step();
    chk("R10", rd_vld == 1'b0, {63'd0, rd_vld}, 64'd0);
    rd_start(8'h10); step(); quiet(); step();
    chk("R1", rd_vld && rd_data == d1, rd_data, d1);
    chk("R5", rd_vld == 1'b1, {63'd0, rd_vld}, 64'd1);

    // R2 per-lane write, lanes 0..3 enabled
    cur_req = "R2";
    wr_start(8'h10, 1, 0, 8'hF0, d2); step(); quiet(); step();
    rd_start(8'h10); step(); quiet(); step();
    chk("R2", rd_vld && rd_data == merge(d1, d2, 8'hF0), rd_data, merge(d1, d2, 8'hF0));

    // R3 processor strobe with write controls active is a read
    cur_req = "R3";
    rd_start(8'h11); all_wr_n = 0; grp_wr_n = 0; lane_n = 8'h00; wr_data = '1; step();
    quiet(); step();
    chk("R3", rd_vld && rd_data == init_word(8'h11), rd_data, init_word(8'h11));

    // R4 interleaved order
    cur_req = "R4";
    burst_check(8'h21, 1, "R4");

    // R8 sleep freeze with R7 asynchronous enable
    cur_req = "R8";
    rd_start(8'h10); step(); quiet(); step();
    hold_v = merge(d1, d2, 8'hF0);
    sleep = 1;
    for (int i = 0; i < 3; i++) begin
      wr_start(8'h10, 0, 1, 8'h00, 64'h0); step();
      chk("R8", rd_vld && rd_data == hold_v, rd_data, hold_v);
    end
    oe_n = 1; #1;
    chk("R7", rd_vld == 1'b0, {63'd0, rd_vld}, 64'd0);
    oe_n = 0; #1;
    chk("R7", rd_vld == 1'b1, {63'd0, rd_vld}, 64'd1);
    sleep = 0; quiet(); step(); step();
    rd_start(8'h10); step(); quiet(); step();
    chk("R8", rd_vld && rd_data == hold_v, rd_data, hold_v);

    // R9 deselect ends a burst, next selected strobe starts at once
    cur_req = "R9";
    rd_start(8'h24); step();
    cont(0, 1, 1, 8'hFF, '0); step();
    quiet(); strb_cpu_n = 1; strb_sys_n = 0; step();
    cont(0, 1, 1, 8'hFF, '0); step();
    step();
    chk("R9", rd_vld == 1'b0, {63'd0, rd_vld}, 64'd0);
    rd_start(8'h25); step(); quiet(); step();
    chk("R9", rd_vld && rd_data == init_word(8'h25), rd_data, init_word(8'h25));

    cur_req = "R2"; rand_cycles(1500);

    // Phase 2: flow-through, linear
    do_reset(0, 0);
    cur_req = "R4";
    for (int b = 0; b < 4; b++) begin
      wr_start(8'(8'h20 + b), 0, 1, 8'hFF, init_word(8'(8'h20 + b))); step();
    end
    quiet(); step(); step();
    burst_check(8'h21, 0, "R4");
    cur_req = "R4"; rand_cycles(1500);

    // Phase 3: pipelined, interleaved
    do_reset(1, 1);
    cur_req = "R6";
    wr_start(8'h30, 0, 1, 8'hFF, init_word(8'h30)); step();
    quiet(); wr_data = init_word(8'h30); step(); step();
    wr_start(8'h30, 1, 0, 8'h00, 64'h0); step();
    quiet(); lane_n = 8'h0F; wr_data = d6; step();
    lane_n = 8'hFF; wr_data = '0; step();
    rd_start(8'h30); step(); quiet(); step();
    chk("R5", rd_vld == 1'b0, {63'd0, rd_vld}, 64'd0);
    step();
    chk("R6", rd_vld && rd_data == merge(init_word(8'h30), d6, 8'h0F),
        rd_data, merge(init_word(8'h30), d6, 8'h0F));
    cur_req = "R5"; rand_cycles(1500);

    // Phase 4: pipelined, linear
    do_reset(1, 0);
    cur_req = "R6"; rand_cycles(1500);

    cmp_on = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule